// File: doc/BRIEF.md
# Dual-Buffer Frame Fetch Sequencer

This block decides, once per display frame, where the pixel fetch engine reads its data. Two framebuffer regions are described by a top and a bottom byte address each. On a frame-start pulse the sequencer may first pull a palette of 16-bit entries from the start of the current region over a request/response read port. It hands each entry to an external palette store, and it keeps the pixel depth code found in the first entry. From that code, the load mode and the frame geometry it works out the byte offset of the pixel data, the line stride, the first and last line to show (after the subpanel limits) and the start address. Before it publishes these, it checks that the frame fits inside the region.

An accepted frame reports the buffer it used through a condition pulse and optionally a DMA interrupt pulse. In dual mode the block then swaps to the other region for the next frame. A frame that does not fit raises a sync-error pulse and asks the register unit to clear its enable. The published outputs hold still between accepted frames. Enabling the block checks all four region addresses against the memory window and restarts on region 0.

Top module: `ffs_seq`

## Requirements
- R1: After reset `buf_none` is 1, `frame_valid` is 0, no read request is issued and no status pulse fires, until `enable` rises.
- R2: A rising edge of `enable` selects region 0 (`cur_buf`=0, `buf_none`=0) and checks all four region addresses against [MEM_LO, MEM_HI). If any address is outside, `cond_set[2]` pulses, `dma_irq` pulses when `irq_en[1]` is 1, and frame starts are refused until the next rising edge.
- R3: With `load_mode`=1 a frame start is ignored. With `load_mode`=2 no palette is read, the data offset is 0, and the depth code kept from the last palette load is used.
- R4: With `load_mode` 0 or 3, PAL_ENTRIES reads go out, entry i at region top + 2*i. A request stays valid with a stable address until `rd_req_ready`. Data is taken when `rd_rsp_valid` and `rd_rsp_ready` are both 1 and is written out on `pal_we`/`pal_idx`/`pal_data`. `palette_done` pulses once after the last entry.
- R5: Bits 14:12 of entry 0 select the depth: 1→2 bpp, 2→4 bpp, 3→8 bpp, 4..7→16 bpp when `wide_color`=1 and 12 bpp otherwise. Code 0 pulses `unsupported` and leaves every output unchanged.
- R6: After a palette load the data offset is 2*SMALL_ENTRIES bytes (0x20) for codes 1 and 2, and 2*PAL_ENTRIES bytes (0x200) for codes 3..7.
- R7: If offset + width*height*bpp/8 exceeds (bottom − top) + 2, `sync_err` and `en_clear` pulse together, `frame_valid` drops, and frame starts are refused until `enable` rises again. Equality is accepted.
- R8: An accepted frame pulses `cond_set[cur_buf]` (bit 0 or bit 1) and pulses `dma_irq` in the same cycle when `irq_en[0]` is 1.
- R9: With `dual_mode`=1 each accepted frame swaps `cur_buf`, so successive frames use regions 0, 1, 0.
- R10: With `sp_en`=1 and `sp_first`=1, `first_line` = `sp_line` and `last_line` = height−1. With `sp_en`=1 and `sp_first`=0, `first_line`=0 and `last_line` = `sp_line`−1. With `sp_en`=0 the lines are 0 and height−1.
- R11: `stride` = width*bpp/8 bytes and `start_addr` = top + offset + stride*`first_line`.
- R12: The published outputs change only on an accepted frame. A frame start that arrives while a frame is being processed is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Block enable level from the register unit |
| load_mode | input | 2 | 0/3 load palette, 1 no fetch, 2 data only |
| dual_mode | input | 1 | Alternate regions each frame |
| wide_color | input | 1 | Codes 4..7 mean 16 bpp (1) or 12 bpp (0) |
| irq_en | input | 2 | Bit 0 frame interrupt, bit 1 address-error interrupt |
| width | input | DIM_W | Pixels per line |
| height | input | DIM_W | Lines per frame |
| sp_en | input | 1 | Subpanel limit enable |
| sp_first | input | 1 | Subpanel value is first line (1) or line limit (0) |
| sp_line | input | SPL_W | Subpanel line value |
| top0 | input | AW | Region 0 top address |
| bot0 | input | AW | Region 0 bottom address |
| top1 | input | AW | Region 1 top address |
| bot1 | input | AW | Region 1 bottom address |
| frame_start | input | 1 | Frame start pulse |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Sequencer takes read data |
| rd_rsp_data | input | 16 | Read data |
| pal_we | output | 1 | Palette entry write strobe |
| pal_idx | output | IDX_W | Palette entry index |
| pal_data | output | 16 | Palette entry value |
| frame_valid | output | 1 | Published frame outputs are valid |
| start_addr | output | AW | Address of the first shown line |
| stride | output | AW | Bytes per line |
| first_line | output | DIM_W | First line shown |
| last_line | output | DIM_W | Last line shown |
| cur_buf | output | 1 | Region used by the next frame |
| buf_none | output | 1 | No region selected yet |
| palette_done | output | 1 | Palette load finished pulse |
| sync_err | output | 1 | Frame does not fit pulse |
| unsupported | output | 1 | Unknown depth code pulse |
| en_clear | output | 1 | Request to clear enable, pulse |
| cond_set | output | 3 | Condition pulses: region 0, region 1, bad address |
| dma_irq | output | 1 | DMA interrupt pulse |

## Verification
The bench builds the block with its default parameters: a 256-entry palette, 16-entry small palette, 11-bit dimensions and a 1 MiB address window. So the real 0x200 and 0x20 offsets and the full 256 read handshakes per frame are exercised. The 128 KiB regions the bench sets up put a 16 bpp 256×255 frame exactly on the fit limit, so both sides of the size check are reached by moving the bottom address by one byte. The read port is stalled on a repeating ready pattern with a delayed response to exercise back-pressure.

// File: rtl/ffs_pkg.sv
package ffs_pkg;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_LOAD   = 2'd1,
    S_DECIDE = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic       ok;
    logic       big;
    logic [4:0] bpp;
  } depth_t;

endpackage

// File: rtl/ffs_pal_loader.sv
module ffs_pal_loader #(
  parameter int AW          = 32,
  parameter int PAL_ENTRIES = 256,
  localparam int IDX_W      = $clog2(PAL_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    base,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [AW-1:0]    req_addr,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic [15:0]      rsp_data,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [15:0]      wr_data,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAL_ENTRIES - 1);

  logic             busy;
  logic             waiting;
  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    base_q;

  assign req_valid = busy && !waiting;
  assign req_addr  = base_q + AW'({idx, 1'b0});
  assign rsp_ready = busy && waiting;
  assign wr_en     = rsp_ready && rsp_valid;
  assign wr_idx    = idx;
  assign wr_data   = rsp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      waiting <= 1'b0;
      idx     <= '0;
      base_q  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        waiting <= 1'b0;
        idx     <= '0;
        base_q  <= base;
      end else if (req_valid && req_ready) begin
        waiting <= 1'b1;
      end else if (wr_en) begin
        waiting <= 1'b0;
        if (idx == LAST_IDX) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ffs_depth_decode.sv
module ffs_depth_decode
  import ffs_pkg::*;
(
  input  logic [2:0] code,
  input  logic       wide_color,
  output depth_t     depth
);

  always_comb begin
    depth = '{ok: 1'b1, big: 1'b1, bpp: 5'd8};
    unique case (code)
      3'd1: depth = '{ok: 1'b1, big: 1'b0, bpp: 5'd2};
      3'd2: depth = '{ok: 1'b1, big: 1'b0, bpp: 5'd4};
      3'd3: depth = '{ok: 1'b1, big: 1'b1, bpp: 5'd8};
      3'd4, 3'd5, 3'd6, 3'd7:
        depth = '{ok: 1'b1, big: 1'b1, bpp: (wide_color ? 5'd16 : 5'd12)};
      default: depth = '{ok: 1'b0, big: 1'b0, bpp: 5'd0};
    endcase
  end

endmodule

// File: rtl/ffs_geom.sv
module ffs_geom #(
  parameter int AW    = 32,
  parameter int DIM_W = 11,
  parameter int SPL_W = 10
) (
  input  logic [AW-1:0]    top,
  input  logic [AW-1:0]    bot,
  input  logic [AW-1:0]    offset,
  input  logic [4:0]       bpp,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  input  logic             sp_en,
  input  logic             sp_first,
  input  logic [SPL_W-1:0] sp_line,
  output logic [AW-1:0]    stride,
  output logic [AW-1:0]    start,
  output logic [DIM_W-1:0] first,
  output logic [DIM_W-1:0] last,
  output logic             fits
);

  logic [AW-1:0]    w_a, h_a, b_a, bytes;
  logic [AW:0]      total, room;
  logic [DIM_W-1:0] limit;

  always_comb begin
    w_a    = AW'(width);
    h_a    = AW'(height);
    b_a    = AW'(bpp);
    stride = (w_a * b_a) >> 3;
    bytes  = (w_a * h_a * b_a) >> 3;
    total  = {1'b0, bytes} + {1'b0, offset};
    room   = {1'b0, bot - top} + (AW+1)'(2);
    fits   = (total <= room);
    first  = (sp_en && sp_first)  ? DIM_W'(sp_line) : '0;
    limit  = (sp_en && !sp_first) ? DIM_W'(sp_line) : height;
    last   = limit - DIM_W'(1);
    start  = top + offset + stride * AW'(first);
  end

endmodule

// File: rtl/ffs_seq.sv
module ffs_seq
  import ffs_pkg::*;
#(
  parameter int            AW            = 32,
  parameter int            DIM_W         = 11,
  parameter int            SPL_W         = 10,
  parameter int            PAL_ENTRIES   = 256,
  parameter int            SMALL_ENTRIES = 16,
  parameter logic [AW-1:0] MEM_LO        = 32'h1000_0000,
  parameter logic [AW-1:0] MEM_HI        = 32'h1010_0000,
  localparam int           IDX_W         = $clog2(PAL_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [1:0]       load_mode,
  input  logic             dual_mode,
  input  logic             wide_color,
  input  logic [1:0]       irq_en,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  input  logic             sp_en,
  input  logic             sp_first,
  input  logic [SPL_W-1:0] sp_line,
  input  logic [AW-1:0]    top0,
  input  logic [AW-1:0]    bot0,
  input  logic [AW-1:0]    top1,
  input  logic [AW-1:0]    bot1,
  input  logic             frame_start,
  output logic             rd_req_valid,
  input  logic             rd_req_ready,
  output logic [AW-1:0]    rd_req_addr,
  input  logic             rd_rsp_valid,
  output logic             rd_rsp_ready,
  input  logic [15:0]      rd_rsp_data,
  output logic             pal_we,
  output logic [IDX_W-1:0] pal_idx,
  output logic [15:0]      pal_data,
  output logic             frame_valid,
  output logic [AW-1:0]    start_addr,
  output logic [AW-1:0]    stride,
  output logic [DIM_W-1:0] first_line,
  output logic [DIM_W-1:0] last_line,
  output logic             cur_buf,
  output logic             buf_none,
  output logic             palette_done,
  output logic             sync_err,
  output logic             unsupported,
  output logic             en_clear,
  output logic [2:0]       cond_set,
  output logic             dma_irq
);

  localparam int            N_ADDR      = 4;
  localparam logic [AW-1:0] BIG_OFFS    = AW'(PAL_ENTRIES * 2);
  localparam logic [AW-1:0] SMALL_OFFS  = AW'(SMALL_ENTRIES * 2);
  localparam logic [1:0]    MODE_NONE   = 2'd1;
  localparam logic [1:0]    MODE_DATA   = 2'd2;

  seq_state_t state;
  logic       en_q, en_rise, ok_run, loaded, ld_start, ld_done;
  logic [2:0] hdr_code;
  depth_t     depth;

  logic [AW-1:0]     region_addr [N_ADDR];
  logic [N_ADDR-1:0] addr_ok;

  assign region_addr[0] = top0;
  assign region_addr[1] = bot0;
  assign region_addr[2] = top1;
  assign region_addr[3] = bot1;

  for (genvar g = 0; g < N_ADDR; g++) begin : g_addr_chk
    assign addr_ok[g] = (region_addr[g] >= MEM_LO) && (region_addr[g] < MEM_HI);
  end

  assign en_rise = enable && !en_q;

  logic [AW-1:0] sel_top, sel_bot, data_offs;
  assign sel_top   = cur_buf ? top1 : top0;
  assign sel_bot   = cur_buf ? bot1 : bot0;
  assign data_offs = !loaded ? '0 : (depth.big ? BIG_OFFS : SMALL_OFFS);

  ffs_pal_loader #(.AW(AW), .PAL_ENTRIES(PAL_ENTRIES)) u_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (ld_start),
    .base      (sel_top),
    .req_valid (rd_req_valid),
    .req_ready (rd_req_ready),
    .req_addr  (rd_req_addr),
    .rsp_valid (rd_rsp_valid),
    .rsp_ready (rd_rsp_ready),
    .rsp_data  (rd_rsp_data),
    .wr_en     (pal_we),
    .wr_idx    (pal_idx),
    .wr_data   (pal_data),
    .done      (ld_done)
  );

  ffs_depth_decode u_depth (
    .code       (hdr_code),
    .wide_color (wide_color),
    .depth      (depth)
  );

  logic [AW-1:0]    g_stride, g_start;
  logic [DIM_W-1:0] g_first, g_last;
  logic             g_fits;

  ffs_geom #(.AW(AW), .DIM_W(DIM_W), .SPL_W(SPL_W)) u_geom (
    .top      (sel_top),
    .bot      (sel_bot),
    .offset   (data_offs),
    .bpp      (depth.bpp),
    .width    (width),
    .height   (height),
    .sp_en    (sp_en),
    .sp_first (sp_first),
    .sp_line  (sp_line),
    .stride   (g_stride),
    .start    (g_start),
    .first    (g_first),
    .last     (g_last),
    .fits     (g_fits)
  );

  logic can_start;
  assign can_start = frame_start && enable && ok_run && !buf_none &&
                     !en_rise && (load_mode != MODE_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= S_IDLE;
      en_q         <= 1'b0;
      ok_run       <= 1'b0;
      loaded       <= 1'b0;
      ld_start     <= 1'b0;
      hdr_code     <= '0;
      cur_buf      <= 1'b0;
      buf_none     <= 1'b1;
      frame_valid  <= 1'b0;
      start_addr   <= '0;
      stride       <= '0;
      first_line   <= '0;
      last_line    <= '0;
      palette_done <= 1'b0;
      sync_err     <= 1'b0;
      unsupported  <= 1'b0;
      en_clear     <= 1'b0;
      cond_set     <= '0;
      dma_irq      <= 1'b0;
    end else begin
      palette_done <= 1'b0;
      sync_err     <= 1'b0;
      unsupported  <= 1'b0;
      en_clear     <= 1'b0;
      cond_set     <= '0;
      dma_irq      <= 1'b0;
      ld_start     <= 1'b0;
      en_q         <= enable;

      if (pal_we && pal_idx == '0) hdr_code <= pal_data[14:12];
      if (!enable) ok_run <= 1'b0;

      unique case (state)
        S_IDLE: begin
          if (can_start) begin
            loaded <= (load_mode != MODE_DATA);
            if (load_mode != MODE_DATA) begin
              ld_start <= 1'b1;
              state    <= S_LOAD;
            end else begin
              state <= S_DECIDE;
            end
          end
        end
        S_LOAD: begin
          if (ld_done) begin
            palette_done <= 1'b1;
            state        <= S_DECIDE;
          end
        end
        S_DECIDE: begin
          state <= S_IDLE;
          if (ok_run && enable && !en_rise) begin
            if (!depth.ok) begin
              unsupported <= 1'b1;
            end else if (!g_fits) begin
              sync_err    <= 1'b1;
              en_clear    <= 1'b1;
              ok_run      <= 1'b0;
              frame_valid <= 1'b0;
            end else begin
              frame_valid       <= 1'b1;
              start_addr        <= g_start;
              stride            <= g_stride;
              first_line        <= g_first;
              last_line         <= g_last;
              cond_set[cur_buf] <= 1'b1;
              dma_irq           <= irq_en[0];
              if (dual_mode) cur_buf <= !cur_buf;
            end
          end
        end
        default: state <= S_IDLE;
      endcase

      if (en_rise) begin
        cur_buf  <= 1'b0;
        buf_none <= 1'b0;
        if (&addr_ok) begin
          ok_run <= 1'b1;
        end else begin
          ok_run      <= 1'b0;
          cond_set[2] <= 1'b1;
          dma_irq     <= irq_en[1];
        end
      end
    end
  end

endmodule

// File: rtl/ffs_seq_chk.sv
module ffs_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req_valid,
  input logic          rd_req_ready,
  input logic [AW-1:0] rd_req_addr,
  input logic          palette_done,
  input logic          sync_err,
  input logic          en_clear,
  input logic [2:0]    cond_set,
  input logic          dma_irq,
  input logic [AW-1:0] start_addr,
  input logic          frame_valid,
  input logic          buf_none
);

  AST_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    buf_none |-> (!frame_valid && !rd_req_valid && cond_set == 3'b000)); // R1

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr))); // R4

  AST_PDONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    palette_done |-> !rd_req_valid); // R4

  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> (en_clear && !frame_valid)); // R7

  AST_COND_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cond_set)); // R8

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_irq |-> (cond_set != 3'b000)); // R8

  AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(start_addr) |-> (cond_set[0] || cond_set[1])); // R12

endmodule

bind ffs_seq ffs_seq_chk #(.AW(AW)) u_ffs_seq_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .palette_done (palette_done),
  .sync_err     (sync_err),
  .en_clear     (en_clear),
  .cond_set     (cond_set),
  .dma_irq      (dma_irq),
  .start_addr   (start_addr),
  .frame_valid  (frame_valid),
  .buf_none     (buf_none)
);

// File: tb/tb_ffs_seq.sv
module tb_ffs_seq;

  localparam int          AW   = 32;
  localparam int          NPAL = 256;
  localparam logic [31:0] TOP0 = 32'h1000_0000;
  localparam logic [31:0] TOP1 = 32'h1004_0000;
  localparam logic [31:0] RSZ  = 32'h0002_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  load_mode = 2'd0;
  logic        dual_mode = 1'b0;
  logic        wide_color = 1'b0;
  logic [1:0]  irq_en = 2'b01;
  logic [10:0] width = 11'd16;
  logic [10:0] height = 11'd4;
  logic        sp_en = 1'b0, sp_first = 1'b0;
  logic [9:0]  sp_line = '0;
  logic [31:0] top0 = TOP0, bot0 = TOP0 + RSZ, top1 = TOP1, bot1 = TOP1 + RSZ;
  logic        frame_start = 1'b0;
  logic        rd_req_valid, rd_rsp_ready, pal_we;
  logic        rd_req_ready = 1'b0, rd_rsp_valid = 1'b0;
  logic [31:0] rd_req_addr;
  logic [15:0] rd_rsp_data = '0, pal_data;
  logic [7:0]  pal_idx;
  logic        frame_valid, cur_buf, buf_none, palette_done, sync_err, unsupported;
  logic        en_clear, dma_irq;
  logic [31:0] start_addr, stride;
  logic [10:0] first_line, last_line;
  logic [2:0]  cond_set;

  always #2 clk = ~clk;

  ffs_seq dut (.*);

  int checks = 0, errors = 0, cyc = 0;
  int n_req = 0, n_pdone = 0, n_sync = 0, n_unsup = 0, n_clr = 0, n_irq = 0;
  int n_c0 = 0, n_c1 = 0, n_c2 = 0, req_snap = 0;
  logic [31:0] first_addr = '0;
  logic [15:0] last_pal = '0;
  logic [2:0]  mem_code = 3'd3;
  logic        pend = 1'b0;
  logic [31:0] pend_addr = '0;
  logic [1:0]  rcnt = '0;

  // memory model with ready stalls and one-cycle response delay
  always @(posedge clk) begin
    rcnt         <= rcnt + 1'b1;
    rd_req_ready <= (rcnt != 2'd0);
    if (rd_req_valid && rd_req_ready) begin
      pend      <= 1'b1;
      pend_addr <= rd_req_addr;
      n_req     <= n_req + 1;
      if (n_req == req_snap) first_addr <= rd_req_addr;
    end
    if (pend && !rd_rsp_valid) begin
      rd_rsp_valid <= 1'b1;
      rd_rsp_data  <= (pend_addr == top0 || pend_addr == top1) ?
                      {1'b0, mem_code, 12'h000} : pend_addr[15:0];
    end
    if (rd_rsp_valid && rd_rsp_ready) begin
      rd_rsp_valid <= 1'b0;
      pend         <= 1'b0;
    end
    if (pal_we && pal_idx == 8'd255) last_pal <= pal_data;
    if (palette_done) n_pdone <= n_pdone + 1;
    if (sync_err)     n_sync  <= n_sync + 1;
    if (unsupported)  n_unsup <= n_unsup + 1;
    if (en_clear)     n_clr   <= n_clr + 1;
    if (dma_irq)      n_irq   <= n_irq + 1;
    if (cond_set[0])  n_c0    <= n_c0 + 1;
    if (cond_set[1])  n_c1    <= n_c1 + 1;
    if (cond_set[2])  n_c2    <= n_c2 + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // kind: 0 accepted, 1 unsupported, 2 sync error, 3 nothing
  task automatic run_frame(input bit again, output int kind);
    int s0, s1, su, ss;
    s0 = n_c0; s1 = n_c1; su = n_unsup; ss = n_sync;
    req_snap = n_req;
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    if (again) begin
      repeat (10) @(negedge clk);
      frame_start = 1'b1;
      @(negedge clk) frame_start = 1'b0;
    end
    kind = 3;
    for (int t = 0; t < 3000 && kind == 3; t++) begin
      @(negedge clk);
      if (n_c0 != s0 || n_c1 != s1) kind = 0;
      else if (n_unsup != su)       kind = 1;
      else if (n_sync != ss)        kind = 2;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic reenable();
    @(negedge clk) enable = 1'b0;
    @(negedge clk) enable = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]  mode;
    logic [2:0]  code;
    logic        wide;
    logic [10:0] w;
    logic [10:0] h;
    logic        spe;
    logic        spf;
    logic [9:0]  spl;
    logic        unsup;
    logic [4:0]  bpp;
    logic [9:0]  off;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 3'd3, 1'b0, 11'd320, 11'd240, 1'b0, 1'b0, 10'd0,  1'b0, 5'd8,  10'h200},
    '{2'd0, 3'd1, 1'b0, 11'd160, 11'd120, 1'b0, 1'b0, 10'd0,  1'b0, 5'd2,  10'h020},
    '{2'd0, 3'd2, 1'b0, 11'd100, 11'd50,  1'b1, 1'b1, 10'd10, 1'b0, 5'd4,  10'h020},
    '{2'd0, 3'd4, 1'b1, 11'd200, 11'd100, 1'b1, 1'b0, 10'd60, 1'b0, 5'd16, 10'h200},
    '{2'd0, 3'd5, 1'b0, 11'd64,  11'd10,  1'b0, 1'b0, 10'd0,  1'b0, 5'd12, 10'h200},
    '{2'd3, 3'd0, 1'b0, 11'd64,  11'd10,  1'b0, 1'b0, 10'd0,  1'b1, 5'd0,  10'h000},
    '{2'd0, 3'd7, 1'b0, 11'd16,  11'd4,   1'b0, 1'b0, 10'd0,  1'b0, 5'd12, 10'h200},
    '{2'd2, 3'd7, 1'b1, 11'd8,   11'd2,   1'b0, 1'b0, 10'd0,  1'b0, 5'd16, 10'h000}
  };

  initial begin
    int kind, rq, pd, ir, c0;
    logic [31:0] e_str, e_start, prev_start;
    logic [10:0] e_first, e_last;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(frame_valid == 1'b0, "R1 frame_valid", frame_valid, 0);
    chk(buf_none == 1'b1, "R1 buf_none", buf_none, 1);
    chk(rd_req_valid == 1'b0 && n_req == 0, "R1 no reads", n_req, 0);
    chk(n_c0 + n_c1 + n_c2 + n_irq == 0, "R1 no pulses", n_c0 + n_c1 + n_c2 + n_irq, 0);

    enable = 1'b1;
    repeat (3) @(negedge clk);
    chk(buf_none == 1'b0 && cur_buf == 1'b0, "R2 enable selects region 0", {buf_none, cur_buf}, 0);
    chk(n_c2 == 0, "R2 good addresses no error", n_c2, 0);

    prev_start = start_addr;
    foreach (VECS[i]) begin
      load_mode = VECS[i].mode; mem_code = VECS[i].code; wide_color = VECS[i].wide;
      width = VECS[i].w; height = VECS[i].h;
      sp_en = VECS[i].spe; sp_first = VECS[i].spf; sp_line = VECS[i].spl;
      pd = n_pdone; ir = n_irq; c0 = n_c0;
      run_frame(1'b0, kind);
      rq = n_req - req_snap;
      if (VECS[i].mode != 2'd2) begin
        chk(rq == NPAL, "R4 palette read count", rq, NPAL);
        chk(first_addr == TOP0, "R4 first read address", first_addr, TOP0);
        chk(last_pal == 16'h01FE, "R4 last palette entry", last_pal, 16'h01FE);
        chk(n_pdone == pd + 1, "R4 palette_done once", n_pdone - pd, 1);
      end else begin
        chk(rq == 0 && n_pdone == pd, "R3 data-only mode reads nothing", rq, 0);
      end
      if (VECS[i].unsup) begin
        chk(kind == 1, "R5 code 0 unsupported", kind, 1);
        chk(start_addr == prev_start, "R5 outputs kept on unsupported", start_addr, prev_start);
      end else begin
        e_str   = (32'(VECS[i].w) * 32'(VECS[i].bpp)) >> 3;
        e_first = (VECS[i].spe && VECS[i].spf) ? 11'(VECS[i].spl) : 11'd0;
        e_last  = ((VECS[i].spe && !VECS[i].spf) ? 11'(VECS[i].spl) : VECS[i].h) - 11'd1;
        e_start = TOP0 + 32'(VECS[i].off) + e_str * 32'(e_first);
        chk(kind == 0, "R5 frame accepted", kind, 0);
        chk(stride == e_str, "R11 stride", stride, e_str);
        chk(start_addr == e_start, "R6 R11 start address", start_addr, e_start);
        chk(first_line == e_first, "R10 first line", first_line, e_first);
        chk(last_line == e_last, "R10 last line", last_line, e_last);
        chk(n_c0 == c0 + 1 && n_irq == ir + 1, "R8 cond bit 0 and irq", n_c0 - c0, 1);
        chk(frame_valid == 1'b1, "R8 frame_valid", frame_valid, 1);
        prev_start = start_addr;
      end
    end

    // R3: mode 1 ignores frame start
    load_mode = 2'd1; rq = n_req;
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    repeat (100) @(negedge clk);
    chk(n_req == rq && start_addr == prev_start, "R3 mode 1 no fetch", n_req - rq, 0);

    // R9 dual toggle, R12 busy frame start ignored, R8 irq disabled
    load_mode = 2'd0; mem_code = 3'd3; wide_color = 1'b0;
    width = 11'd32; height = 11'd8; sp_en = 1'b0;
    dual_mode = 1'b1; irq_en = 2'b00; ir = n_irq;
    run_frame(1'b1, kind);
    chk(n_req - req_snap == NPAL, "R12 busy frame start ignored", n_req - req_snap, NPAL);
    chk(kind == 0 && start_addr == TOP0 + 32'h200, "R9 frame 1 region 0", start_addr, TOP0 + 32'h200);
    chk(cur_buf == 1'b1, "R9 swapped to region 1", cur_buf, 1);
    c0 = n_c1;
    run_frame(1'b0, kind);
    chk(first_addr == TOP1, "R9 palette read from region 1", first_addr, TOP1);
    chk(start_addr == TOP1 + 32'h200 && n_c1 == c0 + 1, "R9 frame 2 region 1", start_addr, TOP1 + 32'h200);
    run_frame(1'b0, kind);
    chk(start_addr == TOP0 + 32'h200, "R9 frame 3 back to region 0", start_addr, TOP0 + 32'h200);
    chk(n_irq == ir, "R8 no irq when irq_en[0]=0", n_irq - ir, 0);
    run_frame(1'b0, kind);
    chk(cur_buf == 1'b0, "R9 state before re-enable", cur_buf, 0);
    reenable();
    chk(cur_buf == 1'b0, "R2 re-enable restarts at region 0", cur_buf, 0);

    // R7 fit boundary: 16 bpp 256x255 + 0x200 offset
    dual_mode = 1'b0; irq_en = 2'b01; mem_code = 3'd4; wide_color = 1'b1;
    width = 11'd256; height = 11'd255;
    bot0 = TOP0 + 32'd512 + 32'd130560 - 32'd2;
    run_frame(1'b0, kind);
    chk(kind == 0, "R7 exact fit accepted", kind, 0);
    bot0 = bot0 - 32'd1;
    ir = n_clr;
    run_frame(1'b0, kind);
    chk(kind == 2, "R7 one byte over rejected", kind, 2);
    chk(n_clr == ir + 1 && frame_valid == 1'b0, "R7 en_clear and frame_valid drop", n_clr - ir, 1);
    rq = n_req;
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    repeat (50) @(negedge clk);
    chk(n_req == rq, "R7 halted until enable rises", n_req - rq, 0);
    bot0 = TOP0 + RSZ;
    reenable();

    // R2 address window error
    top1 = 32'h2000_0000; irq_en = 2'b10; ir = n_irq; c0 = n_c2;
    reenable();
    chk(n_c2 == c0 + 1, "R2 bad address cond bit 2", n_c2 - c0, 1);
    chk(n_irq == ir + 1, "R2 address irq with irq_en[1]", n_irq - ir, 1);
    rq = n_req;
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    repeat (50) @(negedge clk);
    chk(n_req == rq, "R2 frames refused after bad address", n_req - rq, 0);
    top1 = TOP1;
    reenable();
    width = 11'd16; height = 11'd4;
    run_frame(1'b0, kind);
    chk(kind == 0, "R2 recovers after valid re-enable", kind, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule